// File: doc/BRIEF.md
# Double-Edge Link Transmitter

This block turns a stream of 16-bit short words into a source-synchronous serial link. The link has four data lanes or one data lane. Data moves on both the rising and the falling edge of a transmit clock that the block generates. The link clock runs at one of four ratios to the core clock. All timing comes from a single reference clock that runs at four times the core rate, so every half-period of the link clock is a whole number of reference cycles.

Words arrive on a valid/ready stream. Each word can carry a flag that marks the end of a block. The far end controls the flow with a level acknowledge. Transmission starts a fixed, ratio-scaled delay after the block first samples the acknowledge high. Transmission stops only between words: either when the acknowledge has been low long enough, or when no further word is waiting. When a flagged word has been sent, a block-complete output pulses for three word times.

Top module: `ddrLinkTx`

## Requirements
- R1: After reset, linkClk, linkData and blkDone are 0. While the link is idle, inReady is 0 whenever ackIn is low. inReady is high exactly when the one-word holding slot is empty and either ackIn is high or the link is busy.
- R2: ratioSel selects the half-period H of linkClk in reference cycles: 0 gives 2, 1 gives 3, 2 gives 4 and 3 gives 8 (link clock ratio 1, 1.5, 2 and 4). While running, every high phase and every low phase of linkClk lasts exactly H cycles.
- R3: Suppose the idle link samples ackIn high with a word held or offered. The first rising edge of linkClk then comes exactly 32·H reference cycles after that sampling edge, which is 16 times the ratio in core periods.
- R4: When widthSel is 0, a word goes out on linkData[3:0] as four nibbles, least significant nibble first. When widthSel is 1, it goes out on linkData[0] as 16 bits, least significant bit first, and linkData[3:1] stays 0. The first group of each word belongs to a rising edge, and each later group to the next edge of either polarity.
- R5: Each data group is driven floor(H/2) cycles before its clock edge. It does not change on the cycle of that edge.
- R6: While a next word is held at the word boundary, words follow each other with no gap. This holds even when ackIn drops for fewer than 32·H cycles.
- R7: The block decides at each word boundary, at the point where the next word's first group would be driven. It stops if ackIn has been sampled low on each of the last 32·H cycles up to and including that point. When stopped, linkClk rests low and linkData keeps the last group sent.
- R8: The block also stops at a word boundary when no word is held. An idle link with ackIn high and no word offered keeps linkClk low.
- R9: blkDone rises on the same cycle as the final falling edge of a word that was accepted with inEnd set. It stays high for exactly 3 word times, that is 3·E·H cycles, where E is 4 edges per word on four lanes or 16 on one lane.
- R10: ratioSel and widthSel are taken only while the link is idle. Changing them during a transfer alters neither the timing nor the lane format of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, four times the core rate |
| rst | input | 1 | Synchronous active-high reset |
| ratioSel | input | 2 | Link clock ratio select |
| widthSel | input | 1 | 0: four lanes, 1: one lane |
| inValid | input | 1 | Short word offered |
| inWord | input | 16 | Short word |
| inEnd | input | 1 | Word is the last of a block |
| inReady | output | 1 | Word accepted on this cycle when inValid is high |
| ackIn | input | 1 | Receiver acknowledge level |
| linkClk | output | 1 | Transmit clock |
| linkData | output | 4 | Link data lanes |
| blkDone | output | 1 | Block-complete pulse |

## Verification
inReady is combinational, so it is checked a moment after the input change that drives it. The bench numbers every reference edge and samples all outputs half a cycle after each edge. From that numbering it predicts where each event must fall. The first linkClk rise must fall exactly 32·H edges after the edge that took ackIn high. Each later toggle must follow the previous one by exactly H edges, and each data change must come exactly floor(H/2) edges before its toggle. blkDone must be seen high on the same sample as the flagged word's final fall, still high 3·E·H−1 samples later, and low on the next. For the stop rule, the bench computes from the decision-point formula which word boundary first has a full low window, and from that how many edges must appear.

// File: rtl/ddrLinkTxPkg.sv
package ddrLinkTxPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RUN
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWord;   // drive first group of the held word
    logic loadGrp;    // drive next group of the current word
    logic oneLane;    // latched lane format
    logic busy;       // link not idle
  } txStb_t;

  // half-period of the link clock in reference cycles
  function automatic int unsigned halfRefs(input logic [1:0] sel,
                                           input int unsigned refPerCore);
    int unsigned ratioX2;
    case (sel)
      2'd0:    ratioX2 = 2;
      2'd1:    ratioX2 = 3;
      2'd2:    ratioX2 = 4;
      default: ratioX2 = 8;
    endcase
    return refPerCore * ratioX2 / 4;
  endfunction

endpackage

// File: rtl/ddrLinkTxCtrl.sv
module ddrLinkTxCtrl
  import ddrLinkTxPkg::*;
#(
  parameter int WORD_W          = 16,
  parameter int LANES           = 4,
  parameter int REF_PER_CORE    = 4,
  parameter int ACK_WIN_CORE    = 16,
  parameter int DONE_HOLD_WORDS = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ratioSel,
  input  logic       widthSel,
  input  logic       ackIn,
  input  logic       inValid,
  input  logic       holdFull,
  input  logic       curEnd,
  output txStb_t     stb,
  output logic       linkClk,
  output logic       blkDone
);

  localparam int MAX_HALF = REF_PER_CORE * 2;
  localparam int HALF_W   = $clog2(MAX_HALF + 1);
  localparam int GRP_W    = $clog2(WORD_W);
  localparam int WIN_MAX  = ACK_WIN_CORE * 2 * MAX_HALF;
  localparam int WIN_W    = $clog2(WIN_MAX + 1);
  localparam int HOLD_MAX = DONE_HOLD_WORDS * WORD_W * MAX_HALF;
  localparam int HOLD_W   = $clog2(HOLD_MAX + 1);

  txState_t          state;
  logic [HALF_W-1:0] halfR, halfNext, phase, lead;
  logic              oneR;
  logic [WIN_W-1:0]  waitCnt, ackLowCnt, winLen;
  logic [GRP_W-1:0]  grpIdx, edgeIdx, grpLast;
  logic [HOLD_W-1:0] holdCnt, holdLen;
  logic              atToggle, atLoad, wordEdge, ackWindow, stopNow;

  always_comb begin
    halfNext  = HALF_W'(halfRefs(ratioSel, REF_PER_CORE));
    lead      = halfR - (halfR >> 1);
    winLen    = WIN_W'(ACK_WIN_CORE * 2 * int'(halfR));
    grpLast   = oneR ? GRP_W'(WORD_W - 1) : GRP_W'(WORD_W / LANES - 1);
    holdLen   = HOLD_W'(DONE_HOLD_WORDS * (int'(grpLast) + 1) * int'(halfR));
    atToggle  = (state == ST_RUN) && (phase == halfR - HALF_W'(1));
    atLoad    = (state == ST_RUN) && (phase == lead - HALF_W'(1));
    wordEdge  = atLoad && (grpIdx == '0);
    ackWindow = !ackIn && (ackLowCnt >= winLen - WIN_W'(1));
    stopNow   = wordEdge && (ackWindow || !holdFull);
    stb.loadWord = wordEdge && !stopNow;
    stb.loadGrp  = atLoad && (grpIdx != '0);
    stb.oneLane  = oneR;
    stb.busy     = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      halfR     <= halfNext;
      oneR      <= 1'b0;
      phase     <= '0;
      waitCnt   <= '0;
      ackLowCnt <= '0;
      grpIdx    <= '0;
      edgeIdx   <= '0;
      linkClk   <= 1'b0;
      blkDone   <= 1'b0;
      holdCnt   <= '0;
    end else begin
      if (ackIn) ackLowCnt <= '0;
      else if (!(&ackLowCnt)) ackLowCnt <= ackLowCnt + WIN_W'(1);

      case (state)
        ST_IDLE: begin
          halfR   <= halfNext;
          oneR    <= widthSel;
          phase   <= '0;
          waitCnt <= '0;
          grpIdx  <= '0;
          edgeIdx <= '0;
          if (ackIn && (holdFull || inValid)) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!ackIn) state <= ST_IDLE;
          else if (waitCnt == winLen - WIN_W'(halfR) - WIN_W'(1)) begin
            state <= ST_RUN;
            phase <= '0;
          end else waitCnt <= waitCnt + WIN_W'(1);
        end
        ST_RUN: begin
          phase <= atToggle ? '0 : phase + HALF_W'(1);
          if (atToggle) begin
            linkClk <= ~linkClk;
            edgeIdx <= (edgeIdx == grpLast) ? '0 : edgeIdx + GRP_W'(1);
          end
          if (stopNow) state <= ST_IDLE;
          else if (atLoad) grpIdx <= (grpIdx == grpLast) ? '0 : grpIdx + GRP_W'(1);
        end
        default: state <= ST_IDLE;
      endcase

      if (atToggle && (edgeIdx == grpLast) && curEnd) begin
        blkDone <= 1'b1;
        holdCnt <= holdLen - HOLD_W'(1);
      end else if (blkDone) begin
        if (holdCnt == '0) blkDone <= 1'b0;
        else holdCnt <= holdCnt - HOLD_W'(1);
      end
    end
  end

endmodule

// File: rtl/ddrLinkTxPath.sv
module ddrLinkTxPath
  import ddrLinkTxPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  txStb_t            stb,
  input  logic              ackIn,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inEnd,
  output logic              inReady,
  output logic              holdFull,
  output logic              curEnd,
  output logic [LANES-1:0]  linkData
);

  logic [WORD_W-1:0] hold, shiftR;
  logic              holdEnd, accept;

  // group on the lanes: full width, or bit 0 on lane 0 only
  function automatic logic [LANES-1:0] laneGrp(input logic [WORD_W-1:0] w,
                                               input logic one);
    return one ? LANES'(w[0]) : w[LANES-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] dropGrp(input logic [WORD_W-1:0] w,
                                                input logic one);
    return one ? (w >> 1) : (w >> LANES);
  endfunction

  assign inReady = !holdFull && (stb.busy || ackIn);
  assign accept  = inValid && inReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= '0;
      holdEnd  <= 1'b0;
      holdFull <= 1'b0;
      shiftR   <= '0;
      curEnd   <= 1'b0;
      linkData <= '0;
    end else begin
      if (accept) begin
        hold     <= inWord;
        holdEnd  <= inEnd;
        holdFull <= 1'b1;
      end else if (stb.loadWord) holdFull <= 1'b0;

      if (stb.loadWord) begin
        linkData <= laneGrp(hold, stb.oneLane);
        shiftR   <= dropGrp(hold, stb.oneLane);
        curEnd   <= holdEnd;
      end else if (stb.loadGrp) begin
        linkData <= laneGrp(shiftR, stb.oneLane);
        shiftR   <= dropGrp(shiftR, stb.oneLane);
      end
    end
  end

endmodule

// File: rtl/ddrLinkTx.sv
module ddrLinkTx
  import ddrLinkTxPkg::*;
#(
  parameter int WORD_W          = 16,
  parameter int LANES           = 4,
  parameter int REF_PER_CORE    = 4,
  parameter int ACK_WIN_CORE    = 16,
  parameter int DONE_HOLD_WORDS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ratioSel,
  input  logic              widthSel,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inEnd,
  output logic              inReady,
  input  logic              ackIn,
  output logic              linkClk,
  output logic [LANES-1:0]  linkData,
  output logic              blkDone
);

  txStb_t stb;
  logic   holdFull, curEnd;

  ddrLinkTxCtrl #(
    .WORD_W(WORD_W), .LANES(LANES), .REF_PER_CORE(REF_PER_CORE),
    .ACK_WIN_CORE(ACK_WIN_CORE), .DONE_HOLD_WORDS(DONE_HOLD_WORDS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .ratioSel(ratioSel), .widthSel(widthSel),
    .ackIn(ackIn), .inValid(inValid), .holdFull(holdFull), .curEnd(curEnd),
    .stb(stb), .linkClk(linkClk), .blkDone(blkDone)
  );

  ddrLinkTxPath #(
    .WORD_W(WORD_W), .LANES(LANES)
  ) u_path (
    .clk(clk), .rst(rst), .stb(stb), .ackIn(ackIn), .inValid(inValid),
    .inWord(inWord), .inEnd(inEnd), .inReady(inReady), .holdFull(holdFull),
    .curEnd(curEnd), .linkData(linkData)
  );

endmodule

// File: rtl/ddrLinkTxChk.sv
module ddrLinkTxChk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             linkClk,
  input logic [LANES-1:0] linkData,
  input logic             blkDone
);

  AST_DATA_STILL_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (linkClk != $past(linkClk)) |-> (linkData == $past(linkData))); // R5

  AST_CLK_HIGH_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(linkClk) |=> linkClk); // R2

  AST_CLK_LOW_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(linkClk) |=> !linkClk); // R2

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(blkDone) |-> $fell(linkClk)); // R9

  AST_DONE_MIN_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(blkDone) |-> $past(blkDone, 2)); // R9

endmodule

bind ddrLinkTx ddrLinkTxChk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .linkClk(linkClk), .linkData(linkData), .blkDone(blkDone)
);

// File: tb/sim_ddrLinkTx.sv
module sim_ddrLinkTx;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam int VRS[NVEC] = '{0, 1, 2, 3, 1, 3};
  localparam int VWS[NVEC] = '{0, 0, 1, 0, 1, 1};
  localparam int VN [NVEC] = '{3, 2, 2, 2, 1, 1};
  localparam logic [15:0] VSEED[NVEC] = '{16'hA5C3, 16'h1E2D, 16'h6B94, 16'hF081, 16'h3CC5, 16'h9A17};
  localparam bit VEND[NVEC] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] ratioSel = 2'd0;
  logic widthSel = 1'b0, inValid = 1'b0, inEnd = 1'b0, ackIn = 1'b0;
  logic [15:0] inWord = '0;
  logic inReady, linkClk, blkDone;
  logic [3:0] linkData;

  int cyc = 0, total = 0, bad = 0, wrI = 0, rdI = 0;
  bit finished = 0;
  logic [15:0] accQ[0:255];
  bit accEnd[0:255];

  ddrLinkTx u0 (
    .clk(clk), .rst(rst), .ratioSel(ratioSel), .widthSel(widthSel),
    .inValid(inValid), .inWord(inWord), .inEnd(inEnd), .inReady(inReady),
    .ackIn(ackIn), .linkClk(linkClk), .linkData(linkData), .blkDone(blkDone)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk)
    if (!rst && inValid && inReady) begin
      accQ[wrI[7:0]]   <= inWord;
      accEnd[wrI[7:0]] <= inEnd;
      wrI <= wrI + 1;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int halfOf(input int rs);
    case (rs)
      0: return 2;
      1: return 3;
      2: return 4;
      default: return 8;
    endcase
  endfunction

  // words sent before the ack window forces a stop (R7)
  function automatic int stopWords(input int h, input int epw, input int lowAt, input int nW);
    int win = 32 * h;
    for (int k = 1; k < nW; k++) begin
      int d = win - h / 2 + k * epw * h;
      if (d - (lowAt + 1) + 1 >= win) return k;
    end
    return nW;
  endfunction

  task automatic xfer(input int rs, input int ws, input int nW, input logic [15:0] seed,
                      input bit endLast, input int lowAt, input int highAt, input int expIn,
                      input bit midCfg, input string tag);
    int h, epw, win, wp, expW, startWr, ackCyc, endCyc, edges, lastTog, lastChg, blkRise, gi, sent;
    logic prevClk;
    logic [3:0] prevData, expGrp, lastGrp;
    logic [15:0] w;
    h = halfOf(rs); epw = ws ? 16 : 4; win = 32 * h; wp = epw * h;
    expW = (expIn < 0) ? (wrI - rdI + nW) : expIn;
    startWr = wrI; edges = 0; lastTog = -1; lastChg = -1; blkRise = -1;
    ratioSel = 2'(rs); widthSel = ws[0];
    sent = 0;
    inValid = (nW > 0); inWord = seed; inEnd = endLast && (nW == 1);
    ackIn = 1'b1;
    ackCyc = cyc + 1;
    prevClk = linkClk; prevData = linkData; lastGrp = linkData;
    endCyc = ackCyc + win + (expW + 3) * wp + 16;
    while (cyc < endCyc) begin
      @(negedge clk);
      if (linkClk !== prevClk) begin
        edges++;
        if (edges == 1) chk(cyc == ackCyc + win, "R3 first edge", cyc - ackCyc, win);
        else chk(cyc - lastTog == h, "R2 half period", cyc - lastTog, h);
        chk(linkData === prevData, "R5 data still at edge", linkData, prevData);
        if (lastChg > lastTog) chk(cyc - lastChg == h / 2, "R5 lead", cyc - lastChg, h / 2);
        gi = (edges - 1) % epw;
        w = accQ[rdI[7:0]];
        expGrp = ws ? {3'b000, w[gi]} : w[4*gi +: 4];
        chk(linkData === expGrp, "R4 group order", linkData, expGrp);
        if (gi == 0) chk(linkClk == 1'b1, "R4 word starts on rise", linkClk, 1);
        lastGrp = linkData;
        if (gi == epw - 1) begin
          if (accEnd[rdI[7:0]]) begin
            chk(blkDone == 1'b1, "R9 done rise", blkDone, 1);
            blkRise = cyc;
          end
          rdI++;
        end
        lastTog = cyc;
      end else if (linkData !== prevData) lastChg = cyc;
      if (blkRise >= 0 && cyc == blkRise + 3 * wp - 1) chk(blkDone == 1'b1, "R9 done held", blkDone, 1);
      if (blkRise >= 0 && cyc == blkRise + 3 * wp) chk(blkDone == 1'b0, "R9 done end", blkDone, 0);
      if (lowAt >= 0 && cyc - ackCyc == lowAt) ackIn = 1'b0;
      if (highAt >= 0 && cyc - ackCyc == highAt) ackIn = 1'b1;
      if (midCfg && edges == 2) begin ratioSel = 2'(rs + 1); widthSel = !ws[0]; end
      sent = wrI - startWr;
      inValid = (sent < nW);
      inWord = seed ^ 16'(sent * 16'h2B47);
      inEnd = endLast && (sent == nW - 1);
      prevClk = linkClk; prevData = linkData;
    end
    chk(edges == expW * epw, {tag, " edge count"}, edges, expW * epw);
    chk(linkClk == 1'b0, "R7 clock parks low", linkClk, 0);
    chk(linkData === lastGrp, "R7 data holds", linkData, lastGrp);
    ackIn = 1'b0; inValid = 1'b0; inEnd = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (CLK_PERIOD * 0 + 200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int stopN;
    bit moved;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(linkClk == 1'b0, "R1 reset clk", linkClk, 0);
    chk(linkData == 4'h0, "R1 reset data", linkData, 0);
    chk(blkDone == 1'b0, "R1 reset done", blkDone, 0);
    chk(inReady == 1'b0, "R1 ready without ack", inReady, 0);

    // R8 idle with ack high but nothing offered
    ackIn = 1'b1;
    #1 chk(inReady == 1'b1, "R1 ready with ack", inReady, 1);
    moved = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (linkClk !== 1'b0) moved = 1;
    end
    chk(!moved, "R8 no clock without word", moved, 0);
    ackIn = 1'b0;
    @(negedge clk);

    // table of transfers, each ending on an empty slot (R6 back-to-back)
    for (int i = 0; i < NVEC; i++)
      xfer(VRS[i], VWS[i], VN[i], VSEED[i], VEND[i], -1, -1, -1, 1'b0, "R6");

    // R7 stop on a full low window with a word still waiting
    stopN = stopWords(2, 4, 100, 20);
    xfer(0, 0, 20, 16'h5AF1, 1'b0, 100, -1, stopN, 1'b0, "R7");
    chk(inReady == 1'b0, "R1 idle ready needs ack", inReady, 0);
    // R8 leftover word drains and the link stops on empty slot
    xfer(1, 1, 0, 16'h0, 1'b0, -1, -1, -1, 1'b0, "R8");
    // R6 short ack drop inside the window leaves no gap
    xfer(2, 0, 10, 16'hC35A, 1'b1, 148, 248, -1, 1'b0, "R6");
    // R10 select changes during a transfer have no effect
    xfer(0, 1, 2, 16'h7E18, 1'b1, -1, -1, -1, 1'b1, "R10");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule